// File: doc/BRIEF.md
# Transmitter Rate-Change Reset Sequencer

This block changes the line rate of a serial transmit channel while the system runs. It brackets a reconfiguration handshake inside the channel's transmit digital reset. A requester gives it a 2-bit rate code and a one-cycle request. The sequencer then does four things in order:

- It raises the transmit reset and loads the code onto its rate output.
- It fires a single-cycle start strobe to the external reconfiguration engine.
- It waits for that engine's busy flag to rise and then to fall.
- It releases the reset and pulses done.

Busy is brought into the clock domain through two flops before the state machine uses it. Two parameters bound the wait. One limits how long busy may take to rise after the strobe. The other limits how long busy may stay high. Overrunning either limit sets a sticky error flag, and the sequencer releases the reset anyway. The sequencer accepts a request only when it is idle and the transmitter reports that it is running normally.

Top module: `txrate_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tx_digrst_o` is 1, while `start_o`, `done_o` and `err_o` are 0.
- R2: While idle, a request is ignored when `tx_ready_i` is 0. When `tx_ready_i` is 1 while idle, `tx_digrst_o` is driven to 0.
- R3: A request taken while idle with `tx_ready_i` high sets `tx_digrst_o` to 1 and loads `req_rate_i` onto `rate_code_o` at the same clock edge. At that edge `err_o` is also cleared.
- R4: `start_o` goes high for exactly one cycle. That cycle is the one after the acceptance edge, so it always follows a cycle in which the reset and the rate code were already in place.
- R5: Let `busy_i` rise d cycles after the strobe cycle, with d ≤ RISE_LIM−2 (the synchronizer adds two cycles), and stay high for L cycles, with 1 ≤ L ≤ BUSY_LIM. Then `done_o` is high d+L+4 cycles after the strobe cycle and `err_o` is 0.
- R6: `tx_digrst_o` stays 1 from the acceptance edge until the done cycle. It is 0 in the done cycle, and `done_o` lasts exactly one cycle.
- R7: If busy is never seen high, `err_o` is 1 and `done_o` is high RISE_LIM+2 cycles after the strobe cycle.
- R8: If busy rises in time but stays high for more than BUSY_LIM cycles, `err_o` is 1 and `done_o` is high d+BUSY_LIM+4 cycles after the strobe cycle.
- R9: A request made during an active sequence neither causes a second strobe nor changes `rate_code_o`.
- R10: `err_o` holds its value after done until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ready_i | input | 1 | Transmitter running normally |
| req_i | input | 1 | Rate-change request, one cycle |
| req_rate_i | input | 2 | Requested rate code |
| busy_i | input | 1 | Reconfiguration engine busy (asynchronous) |
| tx_digrst_o | output | 1 | Transmit digital reset to the channel |
| rate_code_o | output | 2 | Rate code presented to the engine |
| start_o | output | 1 | One-cycle reconfiguration start strobe |
| done_o | output | 1 | One-cycle sequence-complete pulse |
| err_o | output | 1 | Sticky handshake-timeout flag |

## Verification
The hardest things to reach are the exact edges of the two time windows. The difficulty is that busy reaches the state machine only after two synchronizer stages. The bench models the engine itself: it raises busy a chosen number of cycles after the observed strobe and holds it for a chosen length. It sweeps both numbers across and just beyond each limit. For every pair it predicts the done cycle and the error value arithmetically, and it sometimes injects a competing request in the middle of a sequence.

// File: rtl/txrate_pkg.sv
package txrate_pkg;
    localparam int RATE_W = 2;
    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_STROBE,
        ST_WRISE,
        ST_WFALL,
        ST_REL
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/txrate_sync.sv
module txrate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/txrate_timer.sv
module txrate_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/txrate_fsm.sv
module txrate_fsm
    import txrate_pkg::*;
#(
    parameter int RISE_LIM = 6,
    parameter int BUSY_LIM = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_ready_i,
    input  logic  req_i,
    input  rate_t req_rate_i,
    input  logic  busy_s_i,
    output logic  tx_digrst_o,
    output rate_t rate_code_o,
    output logic  start_o,
    output logic  done_o,
    output logic  err_o
);
    localparam int CNT_W = $clog2(imax(RISE_LIM, BUSY_LIM) + 1);

    seq_state_t       state_q;
    logic             tmr_clr, tmr_exp;
    logic [CNT_W-1:0] tmr_limit;

    assign tmr_clr   = (state_q == ST_STROBE) || (state_q == ST_WRISE && busy_s_i);
    assign tmr_limit = (state_q == ST_WRISE) ? CNT_W'(RISE_LIM) : CNT_W'(BUSY_LIM);

    txrate_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (tmr_clr),
        .limit_i   (tmr_limit),
        .expired_o (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            tx_digrst_o <= 1'b1;
            rate_code_o <= '0;
            start_o     <= 1'b0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            start_o <= 1'b0;
            done_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (tx_ready_i && req_i) begin
                        tx_digrst_o <= 1'b1;
                        rate_code_o <= req_rate_i;
                        err_o       <= 1'b0;
                        state_q     <= ST_ARM;
                    end else if (tx_ready_i) begin
                        tx_digrst_o <= 1'b0;
                    end
                end
                ST_ARM: begin
                    start_o <= 1'b1;
                    state_q <= ST_STROBE;
                end
                ST_STROBE: state_q <= ST_WRISE;
                ST_WRISE: begin
                    if (busy_s_i) begin
                        state_q <= ST_WFALL;
                    end else if (tmr_exp) begin
                        err_o   <= 1'b1;
                        state_q <= ST_REL;
                    end
                end
                ST_WFALL: begin
                    if (!busy_s_i) begin
                        state_q <= ST_REL;
                    end else if (tmr_exp) begin
                        err_o   <= 1'b1;
                        state_q <= ST_REL;
                    end
                end
                ST_REL: begin
                    tx_digrst_o <= 1'b0;
                    done_o      <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txrate_seq.sv
module txrate_seq
    import txrate_pkg::*;
#(
    parameter int RISE_LIM = 6,
    parameter int BUSY_LIM = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_ready_i,
    input  logic        req_i,
    input  logic [1:0]  req_rate_i,
    input  logic        busy_i,
    output logic        tx_digrst_o,
    output logic [1:0]  rate_code_o,
    output logic        start_o,
    output logic        done_o,
    output logic        err_o
);
    logic busy_s;

    txrate_sync #(.STAGES(2)) busy_sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (busy_i),
        .q_o (busy_s)
    );

    txrate_fsm #(.RISE_LIM(RISE_LIM), .BUSY_LIM(BUSY_LIM)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .tx_ready_i  (tx_ready_i),
        .req_i       (req_i),
        .req_rate_i  (req_rate_i),
        .busy_s_i    (busy_s),
        .tx_digrst_o (tx_digrst_o),
        .rate_code_o (rate_code_o),
        .start_o     (start_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );
endmodule

// File: rtl/txrate_seq_chk.sv
module txrate_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_digrst_o,
    input logic [1:0] rate_code_o,
    input logic       start_o,
    input logic       done_o
);
    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    p_start_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
        start_o |-> tx_digrst_o);

    p_rate_preloaded_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(start_o) |-> ($stable(rate_code_o) && $past(tx_digrst_o)));

    p_done_releases_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!tx_digrst_o && $past(tx_digrst_o)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_no_start_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        !(start_o && done_o));
endmodule

bind txrate_seq txrate_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .tx_digrst_o (tx_digrst_o),
    .rate_code_o (rate_code_o),
    .start_o     (start_o),
    .done_o      (done_o)
);

// File: tb/txrate_seq_tb.sv
module txrate_seq_tb_top;
    localparam int RISE = 6;
    localparam int BUSY = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_ready_i = 1'b0;
    logic       req_i = 1'b0;
    logic [1:0] req_rate_i = '0;
    logic       busy_i = 1'b0;
    logic       tx_digrst_o, start_o, done_o, err_o;
    logic [1:0] rate_code_o;

    int vecs = 0;
    int bad  = 0;
    logic last_err = 1'b0;

    always #2 clk = ~clk;

    txrate_seq #(.RISE_LIM(RISE), .BUSY_LIM(BUSY)) dut_i (
        .clk (clk), .rst (rst), .tx_ready_i (tx_ready_i), .req_i (req_i),
        .req_rate_i (req_rate_i), .busy_i (busy_i), .tx_digrst_o (tx_digrst_o),
        .rate_code_o (rate_code_o), .start_o (start_o), .done_o (done_o),
        .err_o (err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    task automatic run_seq(input int rate, input int d, input int len, input bit late_req);
        bit rise_ok, seen;
        int exp_lat, lat, starts;
        bit exp_err, rst_drop;
        rise_ok = (d <= RISE - 2);
        if (!rise_ok)        begin exp_lat = RISE + 2;       exp_err = 1'b1; end
        else if (len <= BUSY) begin exp_lat = d + len + 4;   exp_err = 1'b0; end
        else                 begin exp_lat = d + BUSY + 4;   exp_err = 1'b1; end

        @(negedge clk);
        check("R10 err held before request", err_o, last_err);
        req_i = 1'b1; req_rate_i = rate[1:0];
        @(negedge clk);
        req_i = 1'b0;
        check("R3 reset raised on accept", tx_digrst_o, 1);
        check("R3 rate loaded", rate_code_o, rate);
        check("R3 err cleared", err_o, 0);
        check("R4 no strobe at accept", start_o, 0);
        @(negedge clk);
        check("R4 strobe cycle", start_o, 1);

        seen = 1'b0; lat = 0; starts = 0; rst_drop = 1'b0;
        for (int t = 0; t < 40 && !seen; t++) begin
            if (t > 0) begin
                if (start_o) starts++;
                if (done_o) begin seen = 1'b1; lat = t; end
                else if (!tx_digrst_o) rst_drop = 1'b1;
            end
            busy_i = rise_ok && (t >= d) && (t < d + len);
            req_i = late_req && (t == d + 1);
            req_rate_i = ~rate[1:0];
            if (!seen) @(negedge clk);
        end
        req_i = 1'b0;
        check("R5/R7/R8 done latency", lat, exp_lat);
        check("R5/R7/R8 err value", err_o, exp_err);
        check("R6 reset released at done", tx_digrst_o, 0);
        check("R6 reset held through sequence", rst_drop, 0);
        check("R9 no second strobe", starts, 0);
        check("R9 rate unchanged", rate_code_o, rate);
        last_err = exp_err;
        @(negedge clk);
        check("R6 done one cycle", done_o, 0);
        busy_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset digrst", tx_digrst_o, 1);
        check("R1 reset start", start_o, 0);
        check("R1 reset done", done_o, 0);
        check("R1 reset err", err_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset digrst", tx_digrst_o, 1);

        req_i = 1'b1; req_rate_i = 2'd3;
        @(negedge clk);
        req_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R2 request ignored while not ready", start_o, 0);
        end
        check("R2 rate untouched", rate_code_o, 0);
        check("R2 reset kept", tx_digrst_o, 1);
        tx_ready_i = 1'b1;
        @(negedge clk);
        check("R2 reset released when ready", tx_digrst_o, 0);

        for (int d = 0; d <= RISE + 1; d++) begin
            for (int len = 1; len <= BUSY + 2; len++) begin
                if (d <= RISE - 2 || len == 1)
                    run_seq((d * 7 + len) % 4, d, len, ((d + len) % 3) == 0);
            end
        end
        finish_up();
    end

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end
endmodule